// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the array address for a four-beat synchronous SRAM burst. On a load cycle it captures a complete external address: the upper bits go into a holding register, and the two lowest bits become the starting beat. On each following advance cycle the low bits step to the next beat. The upper bits do not change during the burst.

The beat order is set by a static strap, `order_sel`. In linear order the low bits count up from the starting value and wrap modulo four. In interleaved order the low bits are the starting value XOR the beat index.

A single clock enable freezes the whole sequencer. The block carries no data, so every pin is a plain level-sensitive control or address signal, and there is no valid/ready handshake and no back-pressure. The strap must only change while the sequencer is in reset, or immediately before a load cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `arr_addr` is all zero.
- R2: A rising edge with `ce`=1 and `adv`=0 is a load. From the next cycle `arr_addr` equals the `addr_in` value sampled at that edge, and the beat index restarts at 0.
- R3: With `order_sel`=0 (linear), the low two bits of `arr_addr` at beat k after a load equal (start + k) mod 4.
- R4: With `order_sel`=1 (interleaved), the low two bits of `arr_addr` at beat k equal start XOR (k mod 4).
- R5: An advance after the fourth beat wraps to beat 0 of the same sequence, which gives the starting value again. The sequence then repeats without a reload.
- R6: A rising edge with `ce`=0 leaves `arr_addr` unchanged, whatever the values of `adv` and `addr_in`.
- R7: During advance cycles (`ce`=1, `adv`=1), the upper bits of `arr_addr` keep their loaded value, even when `addr_in` changes.
- R8: A load issued in the middle of a burst discards the old burst. The new sequence starts at beat 0 from the new start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; 0 freezes all state |
| adv | input | 1 | 1 = advance to the next beat, 0 = load a new start |
| order_sel | input | 1 | Static strap: 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External address; the two lowest bits are the start beat |
| arr_addr | output | ADDR_W | Array address: held upper bits concatenated with the beat bits |

## Verification
The hardest state to reach from the ports is the wrap after the fourth beat. Reaching it means several advances in a row without an intervening load, and the result must be checked in both orders and from every start value, because a wrong wrap can still match at start 0. The bench sweeps both orders, all four start values and several upper-bit patterns. Each load is followed by eight advances, and `addr_in` is scrambled during those advances. Enable gaps and a reload in the middle of a burst are then inserted.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic {
    OP_LOAD    = 1'b0,
    OP_ADVANCE = 1'b1
  } op_e;
endpackage

// File: rtl/bac_beat_ctr.sv
// Beat index: cleared on load, incremented with natural wrap on advance.
module bac_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat
);
  import bac_pkg::*;

  op_e op;
  assign op = op_e'(adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (ce) begin
      if (op == OP_LOAD) beat <= '0;
      else               beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/bac_start_reg.sv
// Holds the captured address fields (upper bits and start beat).
module bac_start_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/bac_order_map.sv
// Maps start value and beat index onto the beat address for either order.
module bac_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo
);
  import bac_pkg::*;

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_lo[b] = start[b] ^ beat[b];
  end

  always_comb begin
    unique case (order_e'(order_sel))
      ORD_LINEAR: lo = lin_lo;
      ORD_XOR:    lo = xor_lo;
      default:    lo = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 10,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load_en;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] start_q;
  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] lo;

  assign load_en = ce & ~adv;

  bac_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .ce(ce), .adv(adv), .beat(beat)
  );

  bac_start_reg #(.W(BEAT_W)) u_start (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .d(addr_in[BEAT_W-1:0]), .q(start_q)
  );

  bac_start_reg #(.W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .d(addr_in[ADDR_W-1:BEAT_W]), .q(hi_q)
  );

  bac_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_sel(order_sel), .start(start_q), .beat(beat), .lo(lo)
  );

  assign arr_addr = {hi_q, lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              adv,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] arr_addr
);
  logic [BEAT_W-1:0] lo_now;
  logic [BEAT_W-1:0] lo_inc;
  assign lo_now = arr_addr[BEAT_W-1:0];
  assign lo_inc = lo_now + 1'b1;

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !adv) |=> (arr_addr == $past(addr_in)));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && !order_sel) |=> (lo_now == $past(lo_inc)));

  assert_xor_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && order_sel) |=> (lo_now != $past(lo_now)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> $stable(arr_addr));

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv) |=> $stable(arr_addr[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .adv(adv), .order_sel(order_sel),
  .addr_in(addr_in), .arr_addr(arr_addr)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce = 1'b0;
  logic              adv = 1'b0;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] arr_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .ce(ce), .adv(adv), .order_sel(order_sel),
    .addr_in(addr_in), .arr_addr(arr_addr)
  );

  function automatic logic [1:0] exp_lo(input logic ord, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return ord ? (s ^ kk) : 2'(s + kk);
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (arr_addr !== exp) begin
      errors++;
      $display("FAIL %s: arr_addr=%h expected=%h", req, arr_addr, exp);
    end
  endtask

  // drive at falling edge, one rising edge, then sample at falling edge
  task automatic cyc(input logic c, input logic a, input logic [ADDR_W-1:0] ad);
    ce = c; adv = a; addr_in = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [ADDR_W-1:0] ld;
    logic [ADDR_W-1:0] held;
    @(negedge clk);
    check("R1", '0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", '0);

    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          order_sel = ord[0];
          ld = ADDR_W'(((u * 97 + s * 31 + ord * 13) % 256) * 4 + s);
          cyc(1'b1, 1'b0, ld);
          check("R2", ld);
          for (int k = 1; k <= 8; k++) begin
            cyc(1'b1, 1'b1, ADDR_W'(k * 73 + u));
            check(k >= 4 ? "R5" : (ord != 0 ? "R4" : "R3"),
                  {ld[ADDR_W-1:2], exp_lo(ord[0], ld[1:0], k)});
            checks++;
            if (arr_addr[ADDR_W-1:2] !== ld[ADDR_W-1:2]) begin
              errors++;
              $display("FAIL R7: upper=%h expected=%h", arr_addr[ADDR_W-1:2], ld[ADDR_W-1:2]);
            end
          end
        end
      end
    end

    // R6: enable low, adv and addr toggled
    order_sel = 1'b0;
    ld = 10'h2c1;
    cyc(1'b1, 1'b0, ld);
    cyc(1'b1, 1'b1, '0);
    held = {ld[9:2], exp_lo(1'b0, 2'd1, 1)};
    check("R3", held);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, i[0], ADDR_W'(i * 211 + 5));
      check("R6", held);
    end
    cyc(1'b1, 1'b1, '0);
    check("R6", {ld[9:2], exp_lo(1'b0, 2'd1, 2)});

    // R8: mid-burst reload in both orders
    for (int ord = 0; ord < 2; ord++) begin
      order_sel = ord[0];
      cyc(1'b1, 1'b0, 10'h155);
      cyc(1'b1, 1'b1, '0);
      cyc(1'b1, 1'b1, '0);
      ld = 10'h0ae;
      cyc(1'b1, 1'b0, ld);
      check("R8", ld);
      for (int k = 1; k <= 3; k++) begin
        cyc(1'b1, 1'b1, '1);
        check("R8", {ld[9:2], exp_lo(ord[0], ld[1:0], k)});
      end
    end

    // R1: reset mid-burst
    rst_n = 1'b0;
    cyc(1'b1, 1'b1, '1);
    check("R1", '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule